// File: doc/BRIEF.md
# Clear-on-Read MAC Statistics Counter Bank

This block keeps a set of 32-bit statistics counters for an Ethernet MAC. Some counters count events: each one-cycle pulse on an event input adds one. The others count bytes: a strobed 11-bit byte count is added to the counter on each strobe. Software reads a counter by raising a read strobe with a counter index. The value comes back one cycle later, and the read resets that counter, so each read returns only the activity since the previous read.

A single configuration bit selects a rollover test mode. While the bit is set, a read leaves a preset value in the counter instead of zero. The preset is close to the counter's upper half boundary, so software can watch the counter roll over within a short time. Event counters take one preset and byte-count counters take a lower one, because a byte counter can advance by up to 2047 in one cycle. An increment that arrives in the same cycle as a read is applied on top of the post-read value, so no event is ever lost.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset every counter holds 0, the test-mode bit is 0 and the read-valid output is low.
- R2: With the test-mode bit clear, a read returns the selected counter's value and leaves that counter at 0.
- R3: With the test-mode bit set, a read of an event counter leaves it at 32'h7FFF_FFFC.
- R4: With the test-mode bit set, a read of a byte-count counter leaves it at 32'h7FFF_FF80.
- R5: The test-mode bit is written from `cfg_test_i` on a cycle where `cfg_we_i` is high, and its value is shown on `cfg_test_o`. A read in the same cycle as the write uses the old value.
- R6: Counters wrap from their maximum value to 0 and do not saturate.
- R7: When an increment and a read hit the same counter in the same cycle, the read returns the old value. The counter then holds the post-read value (0 or the preset) plus that cycle's increment.
- R8: An event counter adds 1 for each cycle its pulse bit is high. A byte-count counter adds its 11-bit byte field, zero-extended, on each cycle its valid bit is high.
- R9: Read data and read-valid are registered. They appear in the cycle after the read strobe, and read-valid is high for exactly one cycle per strobe.
- R10: A read with an index of N_EVT+N_LEN or above returns 0 and changes no counter.
- R11: Index i below N_EVT selects event counter i. Index N_EVT+j selects byte-count counter j, whose byte field is `len_bytes_i[j*11 +: 11]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for the test-mode bit |
| cfg_test_i | input | 1 | New value of the test-mode bit |
| cfg_test_o | output | 1 | Current test-mode bit |
| evt_pulse_i | input | N_EVT (6) | One pulse bit per event counter |
| len_valid_i | input | N_LEN (3) | Byte-count strobe per length counter |
| len_bytes_i | input | N_LEN*11 (33) | Packed byte counts, 11 bits per length counter |
| rd_en_i | input | 1 | Read strobe |
| rd_sel_i | input | SEL_W (4) | Counter index to read |
| rd_data_o | output | CNT_W (32) | Registered read value |
| rd_valid_o | output | 1 | High the cycle after a read strobe |

## Verification
Rollover is the hardest condition to reach from the ports. From zero it would take billions of increments, and even from the test preset a 32-bit byte counter needs about a million maximum-size strobes. The bench therefore runs a second instance with 16-bit counters and matching scaled presets. It uses test mode to place a byte counter near its boundary and then drives full 2047-byte strobes until the counter wraps. The read-and-increment collision is forced with directed cycles in which the strobe and the pulse target the same index, both with and without test mode. A reference model checks both instances on every clock.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;

    typedef enum logic {
        KIND_EVENT  = 1'b0,
        KIND_LENGTH = 1'b1
    } cnt_kind_e;

    localparam int LEN_FIELD_W = 11;

endpackage

// File: rtl/mac_stat_cell.sv
module mac_stat_cell
    import mac_stat_pkg::*;
#(
    parameter int                 CNT_W      = 32,
    parameter int                 INC_W      = 11,
    parameter cnt_kind_e          KIND       = KIND_EVENT,
    parameter logic [CNT_W-1:0]   EVT_PRESET = CNT_W'(32'h7FFF_FFFC),
    parameter logic [CNT_W-1:0]   LEN_PRESET = CNT_W'(32'h7FFF_FF80)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_mode_i,
    input  logic             rd_hit_i,
    input  logic             inc_en_i,
    input  logic [INC_W-1:0] inc_val_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] PRESET = (KIND == KIND_LENGTH) ? LEN_PRESET : EVT_PRESET;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cell_t;

    cell_t            s_d, s_q;
    logic [CNT_W-1:0] base_d;
    logic [CNT_W-1:0] addend_d;

    always_comb begin
        s_d = s_q;
        if (rd_hit_i) begin
            base_d = test_mode_i ? PRESET : '0;
        end else begin
            base_d = s_q.cnt;
        end
        addend_d = inc_en_i ? CNT_W'(inc_val_i) : '0;
        s_d.cnt  = base_d + addend_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit_i && !test_mode_i && !inc_en_i) |=> (cnt_o == '0));

    p_preset_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit_i && test_mode_i && !inc_en_i) |=> (cnt_o == PRESET));

    p_add_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hit_i && inc_en_i) |=> (cnt_o == $past(cnt_o) + CNT_W'($past(inc_val_i))));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hit_i && !inc_en_i) |=> $stable(cnt_o));

    p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit_i && !test_mode_i && inc_en_i) |=> (cnt_o == CNT_W'($past(inc_val_i))));

endmodule

// File: rtl/mac_stat_rdmux.sv
module mac_stat_rdmux #(
    parameter int N_TOT = 9,
    parameter int CNT_W = 32,
    parameter int SEL_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en_i,
    input  logic [SEL_W-1:0]       rd_sel_i,
    input  logic [N_TOT*CNT_W-1:0] cnt_flat_i,
    output logic [CNT_W-1:0]       rd_data_o,
    output logic                   rd_valid_o
);

    localparam logic [SEL_W:0] LIMIT = (SEL_W + 1)'(N_TOT);

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] data;
    } rd_t;

    rd_t  s_d, s_q;
    logic in_range_d;

    always_comb begin
        s_d        = s_q;
        in_range_d = ({1'b0, rd_sel_i} < LIMIT);
        s_d.valid  = rd_en_i;
        s_d.data   = '0;
        if (rd_en_i && in_range_d) begin
            for (int i = 0; i < N_TOT; i++) begin
                if (rd_sel_i == SEL_W'(i)) begin
                    s_d.data = cnt_flat_i[i*CNT_W +: CNT_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data_o  = s_q.data;
    assign rd_valid_o = s_q.valid;

    p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);

    p_novalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o);

    p_oob_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && ({1'b0, rd_sel_i} >= LIMIT)) |=> (rd_data_o == '0));

endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
    import mac_stat_pkg::*;
#(
    parameter int               N_EVT      = 6,
    parameter int               N_LEN      = 3,
    parameter int               CNT_W      = 32,
    parameter logic [CNT_W-1:0] EVT_PRESET = CNT_W'(32'h7FFF_FFFC),
    parameter logic [CNT_W-1:0] LEN_PRESET = CNT_W'(32'h7FFF_FF80),
    parameter int               LEN_W      = LEN_FIELD_W,
    parameter int               N_TOT      = N_EVT + N_LEN,
    parameter int               SEL_W      = (N_TOT > 1) ? $clog2(N_TOT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we_i,
    input  logic                   cfg_test_i,
    output logic                   cfg_test_o,
    input  logic [N_EVT-1:0]       evt_pulse_i,
    input  logic [N_LEN-1:0]       len_valid_i,
    input  logic [N_LEN*LEN_W-1:0] len_bytes_i,
    input  logic                   rd_en_i,
    input  logic [SEL_W-1:0]       rd_sel_i,
    output logic [CNT_W-1:0]       rd_data_o,
    output logic                   rd_valid_o
);

    typedef struct packed {
        logic test;
    } cfg_t;

    cfg_t                   cfg_d, cfg_q;
    logic [N_TOT-1:0]       rd_hit;
    logic [N_TOT*CNT_W-1:0] cnt_flat;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we_i) begin
            cfg_d.test = cfg_test_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_test_o = cfg_q.test;

    always_comb begin
        for (int i = 0; i < N_TOT; i++) begin
            rd_hit[i] = rd_en_i && (rd_sel_i == SEL_W'(i));
        end
    end

    for (genvar e = 0; e < N_EVT; e++) begin : g_evt
        mac_stat_cell #(
            .CNT_W      (CNT_W),
            .INC_W      (1),
            .KIND       (KIND_EVENT),
            .EVT_PRESET (EVT_PRESET),
            .LEN_PRESET (LEN_PRESET)
        ) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .test_mode_i (cfg_q.test),
            .rd_hit_i    (rd_hit[e]),
            .inc_en_i    (evt_pulse_i[e]),
            .inc_val_i   (1'b1),
            .cnt_o       (cnt_flat[e*CNT_W +: CNT_W])
        );
    end

    for (genvar l = 0; l < N_LEN; l++) begin : g_len
        mac_stat_cell #(
            .CNT_W      (CNT_W),
            .INC_W      (LEN_W),
            .KIND       (KIND_LENGTH),
            .EVT_PRESET (EVT_PRESET),
            .LEN_PRESET (LEN_PRESET)
        ) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .test_mode_i (cfg_q.test),
            .rd_hit_i    (rd_hit[N_EVT + l]),
            .inc_en_i    (len_valid_i[l]),
            .inc_val_i   (len_bytes_i[l*LEN_W +: LEN_W]),
            .cnt_o       (cnt_flat[(N_EVT + l)*CNT_W +: CNT_W])
        );
    end

    mac_stat_rdmux #(
        .N_TOT (N_TOT),
        .CNT_W (CNT_W),
        .SEL_W (SEL_W)
    ) u_rdmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en_i),
        .rd_sel_i   (rd_sel_i),
        .cnt_flat_i (cnt_flat),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

    p_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (cfg_test_o == $past(cfg_test_i)));

    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we_i |=> $stable(cfg_test_o));

    p_onehot_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_hit));

endmodule

// File: tb/mac_stat_bank_tb.sv
module mac_stat_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 6;
    localparam int NL = 3;
    localparam int NT = NE + NL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_wd = 1'b0;
    logic [NE-1:0] evt = '0;
    logic [NL-1:0] lv = '0;
    logic [NL*11-1:0] lb = '0;
    logic        rd = 1'b0;
    logic [3:0]  sel = '0;

    wire         cfg_test_a, cfg_test_b;
    wire [31:0]  rdata_a;
    wire         rvalid_a;
    wire [15:0]  rdata_b;
    wire         rvalid_b;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    longint m32 [NT];
    longint m16 [NT];
    bit     mtest;
    bit     exp_valid;
    longint exp32, exp16;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_stat_bank u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_test_i(cfg_wd),
        .cfg_test_o(cfg_test_a), .evt_pulse_i(evt), .len_valid_i(lv),
        .len_bytes_i(lb), .rd_en_i(rd), .rd_sel_i(sel),
        .rd_data_o(rdata_a), .rd_valid_o(rvalid_a)
    );

    mac_stat_bank #(
        .CNT_W(16), .EVT_PRESET(16'h7FFC), .LEN_PRESET(16'h7F80)
    ) u_dut16 (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_test_i(cfg_wd),
        .cfg_test_o(cfg_test_b), .evt_pulse_i(evt), .len_valid_i(lv),
        .len_bytes_i(lb), .rd_en_i(rd), .rd_sel_i(sel),
        .rd_data_o(rdata_b), .rd_valid_o(rvalid_b)
    );

    task automatic check(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // Reference model step, evaluated with the inputs present at this edge.
    task automatic model_edge();
        longint inc;
        exp_valid = rd;
        exp32 = (rd && sel < NT) ? m32[sel] : 0;
        exp16 = (rd && sel < NT) ? m16[sel] : 0;
        for (int k = 0; k < NT; k++) begin
            longint b32, b16;
            if (k < NE) inc = evt[k] ? 1 : 0;
            else        inc = lv[k-NE] ? longint'(lb[(k-NE)*11 +: 11]) : 0;
            if (rd && sel == k) begin
                b32 = mtest ? ((k < NE) ? 64'h7FFF_FFFC : 64'h7FFF_FF80) : 0;
                b16 = mtest ? ((k < NE) ? 64'h7FFC : 64'h7F80) : 0;
            end else begin
                b32 = m32[k];
                b16 = m16[k];
            end
            m32[k] = (b32 + inc) % 64'h1_0000_0000;
            m16[k] = (b16 + inc) % 64'h1_0000;
        end
        if (cfg_we) mtest = cfg_wd;
    endtask

    task automatic cyc(input logic [NE-1:0] e, input logic [NL-1:0] v,
                       input logic [NL*11-1:0] b, input logic r, input int s,
                       input logic we = 1'b0, input logic wd = 1'b0);
        evt = e; lv = v; lb = b; rd = r; sel = 4'(s); cfg_we = we; cfg_wd = wd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("rd_valid 32", longint'(rvalid_a), longint'(exp_valid));
        check("rd_valid 16", longint'(rvalid_b), longint'(exp_valid));
        if (exp_valid) begin
            check("rd_data 32", longint'(rdata_a), exp32);
            check("rd_data 16", longint'(rdata_b), exp16);
        end
        check("cfg_test", longint'(cfg_test_a), longint'(mtest));
        evt = '0; lv = '0; rd = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic read_all();
        for (int i = 0; i < NT; i++) cyc('0, '0, '0, 1'b1, i);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NT; i++) begin m32[i] = 0; m16[i] = 0; end
        mtest = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        check("rd_valid after reset", longint'(rvalid_a), 0);
        check("cfg_test after reset", longint'(cfg_test_a), 0);
        rst_n = 1'b1;
        read_all();

        // R8 / R11: each event lane and length lane lands in its own index
        cur_req = "R11";
        cyc(6'b000100, '0, '0, 1'b0, 0);
        cyc('0, 3'b010, {11'd0, 11'd300, 11'd0}, 1'b0, 0);
        cyc('0, '0, '0, 1'b1, 2);
        cyc('0, '0, '0, 1'b1, NE + 1);
        cyc('0, '0, '0, 1'b1, NE + 0);

        cur_req = "R8";
        for (int n = 0; n < 40; n++)
            cyc(NE'($urandom), NL'($urandom), (NL*11)'({$urandom, $urandom}), 1'b0, 0);
        // R2: reads return totals and clear
        cur_req = "R2";
        read_all();
        read_all();

        // R9: back-to-back reads and a read followed by idle
        cur_req = "R9";
        cyc(6'b111111, '0, '0, 1'b1, 0);
        cyc('0, '0, '0, 1'b0, 0);
        cyc('0, '0, '0, 1'b1, 0);

        // R7: collision without test mode
        cur_req = "R7";
        cyc(6'b000001, '0, '0, 1'b0, 0);
        cyc(6'b000001, '0, '0, 1'b1, 0);
        cyc('0, 3'b100, {11'd2047, 22'd0}, 1'b1, NE + 2);
        cyc('0, '0, '0, 1'b1, 0);
        cyc('0, '0, '0, 1'b1, NE + 2);

        // R10: out-of-range reads return 0, nothing changes
        cur_req = "R10";
        for (int n = 0; n < 20; n++)
            cyc(NE'($urandom), NL'($urandom), (NL*11)'({$urandom, $urandom}), 1'b0, 0);
        for (int s = NT; s < 16; s++) cyc('0, '0, '0, 1'b1, s);
        read_all();

        // R5: test bit write, read in same cycle uses old value
        cur_req = "R5";
        cyc(6'b000010, '0, '0, 1'b1, 1, 1'b1, 1'b1);
        cyc('0, '0, '0, 1'b1, 1);

        // R3 / R4: presets after test-mode reads
        cur_req = "R3";
        read_all();
        read_all();
        cur_req = "R4";
        cyc('0, 3'b001, {22'd0, 11'd5}, 1'b1, NE);
        cyc('0, '0, '0, 1'b1, NE);
        // R7 under test mode
        cur_req = "R7";
        cyc(6'b001000, '0, '0, 1'b1, 3);
        cyc('0, '0, '0, 1'b1, 3);

        // R6: wrap on the 16-bit instance from the length preset
        cur_req = "R6";
        cyc('0, '0, '0, 1'b1, NE);
        for (int n = 0; n < 20; n++) cyc('0, 3'b001, {22'd0, 11'd2047}, 1'b0, 0);
        cyc('0, '0, '0, 1'b1, NE);

        // Leave test mode and confirm clearing again (R5, R2)
        cur_req = "R5";
        cyc('0, '0, '0, 1'b0, 0, 1'b1, 1'b0);
        cur_req = "R2";
        read_all();
        read_all();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule